// File: doc/BRIEF.md
# Latchable Parity Bus Transceiver

This block moves a byte-wide word with one parity bit between two bus sides, A and B, in either direction. Each side captures its incoming word and parity in a level-sensitive latch of its own. The latched word is forwarded to the opposite side. A parity path then chooses what goes out on the opposite side's parity line. In generate mode it sends a freshly computed parity. In pass-through mode it sends the latched incoming parity bit unchanged. A single polarity select picks even or odd parity for both directions.

Each side also compares the parity computed from its own latched word against its own latched parity bit. It raises an active-low mismatch flag when they disagree, in either mode. The flag can therefore serve as an interrupt for a corrupted word even while parity is only being passed through. The latch enables are independent: one side can freeze its word while the other side stays transparent. Tri-state pads are split into input, output and output-enable signals. The side that the chip integrator connects to a pad ring uses the enable to drive the pad.

Top module: `lpt_xcvr`

## Requirements
- R1: `b_dat_o` always equals the word held in side A's latch, and `a_dat_o` always equals the word held in side B's latch.
- R2: With `feed_sel` = 0 (generate mode), the forwarded parity line (`b_par_o` for A-to-B, `a_par_o` for B-to-A) equals the XOR of the eight forwarded data bits when `odd_sel` = 0, and equals its inverse when `odd_sel` = 1.
- R3: With `feed_sel` = 1 (pass-through mode), the forwarded parity line equals the parity bit held in the source side's latch.
- R4: `err_a_n` is 0 exactly when the parity computed from side A's latched word (with the `odd_sel` polarity of R2) differs from side A's latched parity bit, and is 1 otherwise; `err_b_n` behaves the same for side B. This holds in both modes.
- R5: While a side's latch enable (`le_a`, `le_b`) is 1 its latch follows its inputs. While it is 0, the latch keeps the word and parity present when the enable fell, and input changes have no effect on the forwarded data, the forwarded parity or that side's error flag.
- R6: The two latch enables are independent: side B stays transparent while side A holds, and side A stays transparent while side B holds.
- R7: `a_oe_o` is 1 exactly when `drv_a_n` is 0, and `b_oe_o` is 1 exactly when `drv_b_n` is 0.
- R8: Side A's error flag depends only on side A's latch. Changing side B's inputs leaves `err_a_n` unchanged, and changing side A's inputs leaves `err_b_n` unchanged.
- R9: `drv_a_n` and `drv_b_n` low together is illegal. Under legal use, at most one of `a_oe_o` and `b_oe_o` is 1, and the checker flags any violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dat_i | input | DATA_W | Word arriving from side A pads |
| a_par_i | input | 1 | Parity bit arriving from side A |
| a_dat_o | output | DATA_W | Word to drive onto side A (from side B latch) |
| a_par_o | output | 1 | Parity to drive onto side A |
| a_oe_o | output | 1 | Pad enable for side A outputs |
| b_dat_i | input | DATA_W | Word arriving from side B pads |
| b_par_i | input | 1 | Parity bit arriving from side B |
| b_dat_o | output | DATA_W | Word to drive onto side B (from side A latch) |
| b_par_o | output | 1 | Parity to drive onto side B |
| b_oe_o | output | 1 | Pad enable for side B outputs |
| le_a | input | 1 | Side A latch transparent when 1 |
| le_b | input | 1 | Side B latch transparent when 1 |
| drv_a_n | input | 1 | Active-low request to drive side A |
| drv_b_n | input | 1 | Active-low request to drive side B |
| feed_sel | input | 1 | 0 generate parity, 1 pass parity through |
| odd_sel | input | 1 | 0 even parity, 1 odd parity |
| err_a_n | output | 1 | Active-low parity mismatch on side A latch |
| err_b_n | output | 1 | Active-low parity mismatch on side B latch |

## Verification
The checker watches combinational relations between the ports continuously. These are the parity carried with forwarded data in both modes, the consistency of each error flag with the forwarded word and parity in pass-through mode, and the rule that at most one side is driven. Latch behaviour involves time and cannot be read from any single instant. Holding while the enable is low, independence of the two latches, and immunity of one side's flag to the other side's inputs therefore show only in the bench's directed scenarios. The bench also sweeps every word, parity bit, mode and polarity in both directions.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_kind_e;

   typedef enum logic {
      PATH_GEN  = 1'b0,
      PATH_FEED = 1'b1
   } par_path_e;

   localparam int unsigned SIDE_A    = 0;
   localparam int unsigned SIDE_B    = 1;
   localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/lpt_hold_latch.sv
module lpt_hold_latch #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              le,
   input  logic [DATA_W-1:0] d_i,
   input  logic              p_i,
   output logic [DATA_W-1:0] q_d,
   output logic              q_p
);
   always_latch begin
      if (le) begin
         q_d <= d_i;
         q_p <= p_i;
      end
   end
endmodule

// File: rtl/lpt_parity_core.sv
module lpt_parity_core #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [DATA_W-1:0] d_i,
   input  lpt_pkg::par_kind_e kind,
   output logic              gen_o
);
   logic raw;

   generate
      if (USE_TREE) begin : g_tree
         assign raw = ^d_i;
      end else begin : g_chain
         logic [DATA_W:0] chain;
         assign chain[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign chain[i+1] = chain[i] ^ d_i[i];
         end
         assign raw = chain[DATA_W];
      end
   endgenerate

   assign gen_o = raw ^ (kind == lpt_pkg::PAR_ODD);
endmodule

// File: rtl/lpt_lane.sv
module lpt_lane #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic              le,
   input  logic [DATA_W-1:0] d_i,
   input  logic              p_i,
   input  lpt_pkg::par_kind_e kind,
   input  lpt_pkg::par_path_e path,
   output logic [DATA_W-1:0] fwd_d,
   output logic              fwd_p,
   output logic              err_n
);
   logic [DATA_W-1:0] q_d;
   logic              q_p;
   logic              gen;

   lpt_hold_latch #(.DATA_W(DATA_W)) u_latch (
      .le  (le),
      .d_i (d_i),
      .p_i (p_i),
      .q_d (q_d),
      .q_p (q_p)
   );

   lpt_parity_core #(.DATA_W(DATA_W), .USE_TREE(USE_TREE)) u_par (
      .d_i   (q_d),
      .kind  (kind),
      .gen_o (gen)
   );

   assign fwd_d = q_d;
   assign fwd_p = (path == lpt_pkg::PATH_FEED) ? q_p : gen;
   assign err_n = ~(gen ^ q_p);
endmodule

// File: rtl/lpt_xcvr.sv
module lpt_xcvr #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [DATA_W-1:0] a_dat_i,
   input  logic              a_par_i,
   output logic [DATA_W-1:0] a_dat_o,
   output logic              a_par_o,
   output logic              a_oe_o,
   input  logic [DATA_W-1:0] b_dat_i,
   input  logic              b_par_i,
   output logic [DATA_W-1:0] b_dat_o,
   output logic              b_par_o,
   output logic              b_oe_o,
   input  logic              le_a,
   input  logic              le_b,
   input  logic              drv_a_n,
   input  logic              drv_b_n,
   input  logic              feed_sel,
   input  logic              odd_sel,
   output logic              err_a_n,
   output logic              err_b_n
);
   import lpt_pkg::*;

   localparam int unsigned NS = NUM_SIDES;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("lpt_xcvr: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] in_d  [NS];
   logic              in_p  [NS];
   logic              in_le [NS];
   logic [DATA_W-1:0] out_d [NS];
   logic              out_p [NS];
   logic              out_e [NS];

   par_kind_e kind;
   par_path_e path;

   assign kind = par_kind_e'(odd_sel);
   assign path = par_path_e'(feed_sel);

   assign in_d[SIDE_A]  = a_dat_i;
   assign in_p[SIDE_A]  = a_par_i;
   assign in_le[SIDE_A] = le_a;
   assign in_d[SIDE_B]  = b_dat_i;
   assign in_p[SIDE_B]  = b_par_i;
   assign in_le[SIDE_B] = le_b;

   for (genvar s = 0; s < NS; s++) begin : g_side
      lpt_lane #(.DATA_W(DATA_W), .USE_TREE(USE_TREE)) u_lane (
         .le    (in_le[s]),
         .d_i   (in_d[s]),
         .p_i   (in_p[s]),
         .kind  (kind),
         .path  (path),
         .fwd_d (out_d[s]),
         .fwd_p (out_p[s]),
         .err_n (out_e[s])
      );
   end

   assign b_dat_o = out_d[SIDE_A];
   assign b_par_o = out_p[SIDE_A];
   assign a_dat_o = out_d[SIDE_B];
   assign a_par_o = out_p[SIDE_B];
   assign err_a_n = out_e[SIDE_A];
   assign err_b_n = out_e[SIDE_B];
   assign a_oe_o  = ~drv_a_n;
   assign b_oe_o  = ~drv_b_n;
endmodule

// File: rtl/lpt_xcvr_chk.sv
module lpt_xcvr_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic [DATA_W-1:0] a_dat_o,
   input logic              a_par_o,
   input logic              a_oe_o,
   input logic [DATA_W-1:0] b_dat_o,
   input logic              b_par_o,
   input logic              b_oe_o,
   input logic              feed_sel,
   input logic              odd_sel,
   input logic              err_a_n,
   input logic              err_b_n
);
   always_comb begin
      AST_ONE_DRIVER: assert (!(a_oe_o && b_oe_o))
         else $error("both sides driven"); // R9
      if (!feed_sel) begin
         AST_GEN_PAR_B: assert (b_par_o == ((^b_dat_o) ^ odd_sel))
            else $error("generated parity wrong toward B"); // R2
         AST_GEN_PAR_A: assert (a_par_o == ((^a_dat_o) ^ odd_sel))
            else $error("generated parity wrong toward A"); // R2
      end else begin
         AST_FEED_ERR_A: assert (err_a_n == (b_par_o == ((^b_dat_o) ^ odd_sel)))
            else $error("side A flag disagrees with passed word"); // R4
         AST_FEED_ERR_B: assert (err_b_n == (a_par_o == ((^a_dat_o) ^ odd_sel)))
            else $error("side B flag disagrees with passed word"); // R4
      end
   end
endmodule

bind lpt_xcvr lpt_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
   .a_dat_o  (a_dat_o),
   .a_par_o  (a_par_o),
   .a_oe_o   (a_oe_o),
   .b_dat_o  (b_dat_o),
   .b_par_o  (b_par_o),
   .b_oe_o   (b_oe_o),
   .feed_sel (feed_sel),
   .odd_sel  (odd_sel),
   .err_a_n  (err_a_n),
   .err_b_n  (err_b_n)
);

// File: tb/lpt_xcvr_tb_top.sv
module lpt_xcvr_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_dat_i = '0, b_dat_i = '0;
   logic         a_par_i = 1'b0, b_par_i = 1'b0;
   logic [W-1:0] a_dat_o, b_dat_o;
   logic         a_par_o, b_par_o, a_oe_o, b_oe_o;
   logic         le_a = 1'b1, le_b = 1'b1;
   logic         drv_a_n = 1'b1, drv_b_n = 1'b1;
   logic         feed_sel = 1'b0, odd_sel = 1'b0;
   logic         err_a_n, err_b_n;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   lpt_xcvr #(.DATA_W(W)) dut_i (
      .a_dat_i(a_dat_i), .a_par_i(a_par_i), .a_dat_o(a_dat_o), .a_par_o(a_par_o),
      .a_oe_o(a_oe_o), .b_dat_i(b_dat_i), .b_par_i(b_par_i), .b_dat_o(b_dat_o),
      .b_par_o(b_par_o), .b_oe_o(b_oe_o), .le_a(le_a), .le_b(le_b),
      .drv_a_n(drv_a_n), .drv_b_n(drv_b_n), .feed_sel(feed_sel), .odd_sel(odd_sel),
      .err_a_n(err_a_n), .err_b_n(err_b_n)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic gpar(input logic [W-1:0] d, input logic odd);
      logic r = odd;
      for (int i = 0; i < W; i++) r = r ^ d[i];
      return r;
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      step();
      // reset-like idle state: zeros, even parity, no error
      chk("R1 idle b_dat", b_dat_o, '0);
      chk("R4 idle err_a", {7'b0, err_a_n}, 8'd1);
      chk("R4 idle err_b", {7'b0, err_b_n}, 8'd1);
      chk("R7 idle oe", {6'b0, a_oe_o, b_oe_o}, 8'd0);

      // exhaustive sweep A-to-B then B-to-A
      drv_b_n = 1'b0;
      for (int m = 0; m < 2; m++)
         for (int o = 0; o < 2; o++)
            for (int p = 0; p < 2; p++)
               for (int d = 0; d < 256; d++) begin
                  @(posedge clk);
                  feed_sel = m[0]; odd_sel = o[0]; a_dat_i = d[W-1:0]; a_par_i = p[0];
                  step();
                  chk("R1 b_dat", b_dat_o, d[W-1:0]);
                  if (m == 0) chk("R2 b_par gen", {7'b0, b_par_o}, {7'b0, gpar(d[W-1:0], o[0])});
                  else        chk("R3 b_par feed", {7'b0, b_par_o}, {7'b0, p[0]});
                  chk("R4 err_a", {7'b0, err_a_n}, {7'b0, gpar(d[W-1:0], o[0]) == p[0]});
                  chk("R7 b_oe", {6'b0, a_oe_o, b_oe_o}, 8'd1);
               end
      @(posedge clk);
      drv_b_n = 1'b1;
      step();
      chk("R9 none driven", {6'b0, a_oe_o, b_oe_o}, 8'd0);
      @(posedge clk);
      drv_a_n = 1'b0;
      for (int m = 0; m < 2; m++)
         for (int o = 0; o < 2; o++)
            for (int p = 0; p < 2; p++)
               for (int d = 0; d < 256; d++) begin
                  @(posedge clk);
                  feed_sel = m[0]; odd_sel = o[0]; b_dat_i = d[W-1:0]; b_par_i = p[0];
                  step();
                  chk("R1 a_dat", a_dat_o, d[W-1:0]);
                  if (m == 0) chk("R2 a_par gen", {7'b0, a_par_o}, {7'b0, gpar(d[W-1:0], o[0])});
                  else        chk("R3 a_par feed", {7'b0, a_par_o}, {7'b0, p[0]});
                  chk("R4 err_b", {7'b0, err_b_n}, {7'b0, gpar(d[W-1:0], o[0]) == p[0]});
                  chk("R9 a_oe only", {6'b0, a_oe_o, b_oe_o}, 8'd2);
               end

      // latch hold and independence
      @(posedge clk);
      drv_a_n = 1'b1; drv_b_n = 1'b0; feed_sel = 1'b0; odd_sel = 1'b0;
      a_dat_i = 8'hA5; a_par_i = 1'b0; le_a = 1'b1;
      step();
      chk("R4 A5 ok", {7'b0, err_a_n}, 8'd1);
      @(posedge clk); le_a = 1'b0;
      @(posedge clk); a_dat_i = 8'h3C; a_par_i = 1'b1;
      step();
      chk("R5 hold b_dat", b_dat_o, 8'hA5);
      chk("R5 hold b_par", {7'b0, b_par_o}, 8'd0);
      chk("R5 hold err_a", {7'b0, err_a_n}, 8'd1);
      @(posedge clk); b_dat_i = 8'h01; b_par_i = 1'b0; le_b = 1'b1;
      step();
      chk("R6 b transparent", a_dat_o, 8'h01);
      chk("R4 err_b mismatch", {7'b0, err_b_n}, 8'd0);
      chk("R8 err_a untouched", {7'b0, err_a_n}, 8'd1);
      @(posedge clk); le_b = 1'b0; le_a = 1'b1;
      step();
      chk("R5 release b_dat", b_dat_o, 8'h3C);
      chk("R4 3C mismatch", {7'b0, err_a_n}, 8'd0);
      @(posedge clk); b_dat_i = 8'h03; b_par_i = 1'b1; a_dat_i = 8'h07; a_par_i = 1'b1;
      step();
      chk("R6 b held", a_dat_o, 8'h01);
      chk("R8 err_b untouched", {7'b0, err_b_n}, 8'd0);
      chk("R6 a transparent", b_dat_o, 8'h07);
      chk("R4 07 ok", {7'b0, err_a_n}, 8'd1);
      @(posedge clk); feed_sel = 1'b1; odd_sel = 1'b1;
      step();
      chk("R3 feed held b", {7'b0, a_par_o}, 8'd0);
      chk("R4 odd err_a", {7'b0, err_a_n}, 8'd0);
      chk("R4 odd err_b", {7'b0, err_b_n}, 8'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule